// File: doc/BRIEF.md
# Vector Element Slot Mapper

This block turns a logical vector element number into the physical place that element occupies inside a group of vector registers. Elements are not laid out register after register. They are dealt out in strips whose size is fixed by the strip width parameter. Successive strips go to successive registers of the group, and the pattern wraps back to the first register once every register has received a strip. The block reports two things for each element: the register offset within the group, and the flat slot number, counted in elements, across the whole group.

There are two ways to use it. A combinational query port maps any index under its own element-width and multiplier setting. A streaming port takes a one-cycle start request, latches the setting it sees with that request, and then produces one mapped element per cycle, from index 0 up to the last element of the group. A single-cycle done flag marks the final element. A load/store sequencer can use the streaming port to walk a whole register group without keeping its own counter.

The register width, the strip width and the largest group multiplier are parameters, and all three are powers of two. Every divide and modulo is therefore a shift or a mask. A multiplier code above the largest one allowed is treated as the largest.

Top module: `vec_slot_mapper`

## Requirements
- R1: For element width EW, elements per strip S = SLEN/EW, elements per register P = VLEN/EW, and lane size L = LMUL·S. The reported register offset is (idx mod L) div S. The slot is offset·P + (idx div L)·S + (idx mod S).
- R2: The element-width code 0, 1, 2, 3 selects 8, 16, 32, 64 bits. The multiplier code is log2 of LMUL (0 to 3 gives 1, 2, 4, 8). The number of elements in a group is vlmax = LMUL·VLEN/EW.
- R3: With a multiplier code of 0, the slot equals the index and the register offset is 0.
- R4: For every index below vlmax, the register offset is below LMUL and the slot is below vlmax. Across all indices of one setting, the slots are all distinct.
- R5: A start seen while idle is accepted at that clock edge and latches the streaming setting. Beats follow on consecutive cycles, starting one cycle after acceptance, carrying indices 0, 1, … vlmax-1.
- R6: Each streamed beat carries the register offset and slot of R1, computed for the latched setting.
- R7: The done output is high for exactly one cycle, together with the beat whose index is vlmax-1. The busy output is low from that cycle on.
- R8: A start request, or a change of the streaming setting, while busy has no effect on the run in progress.
- R9: While reset is asserted, and right after it, busy, beat valid and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_ew | input | 2 | Query element-width code |
| q_mul | input | 2 | Query multiplier code (log2 LMUL) |
| q_idx | input | 7 | Query element index |
| q_reg | output | 3 | Query register offset within the group |
| q_slot | output | 7 | Query flat slot |
| st_start | input | 1 | Start request for a streaming run |
| st_ew | input | 2 | Streaming element-width code, latched on start |
| st_mul | input | 2 | Streaming multiplier code, latched on start |
| st_busy | output | 1 | A run is in progress |
| st_valid | output | 1 | Streamed beat valid |
| st_idx | output | 7 | Index of the streamed beat |
| st_reg | output | 3 | Register offset of the streamed beat |
| st_slot | output | 7 | Slot of the streamed beat |
| st_done | output | 1 | Final beat of the run |

## Verification
The checker watches several properties on every cycle:
- a start taken while idle enters the busy state at index zero;
- the latched setting holds steady through a run;
- beat indices increase by one;
- done is a lone pulse that comes with a valid beat;
- a multiplier of one gives the identity mapping;
- query results stay inside the group.

The exact strip arithmetic for each width and multiplier can only be shown by the bench's scenarios. This covers the hand-worked table entries and the full sweep, which also shows that slots are distinct. The scenarios also show that a disturbing start and a setting change in mid-run leave the later beats on the original mapping, and that reset cuts a run short.

// File: rtl/vsm_pkg.sv
`timescale 1ns/1ps
package vsm_pkg;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_code_e;

  // log2 of the element width in bits
  function automatic int ew_shift(ew_code_e c);
    return 3 + int'(c);
  endfunction

  // log2 of how many elements of width c fit into 2**span_log bits
  function automatic int span_elems_log(int span_log, ew_code_e c);
    return span_log - ew_shift(c);
  endfunction

  // multiplier code limited to the largest supported group
  function automatic int clamp_mul_log(int code, int max_log);
    return (code > max_log) ? max_log : code;
  endfunction

  // log2 of the element count of a whole group
  function automatic int group_elems_log(int vlen_log, int mul_log, ew_code_e c);
    return mul_log + vlen_log - ew_shift(c);
  endfunction

endpackage

// File: rtl/vsm_slot_calc.sv
`timescale 1ns/1ps
module vsm_slot_calc
  import vsm_pkg::*;
#(
  parameter int VLEN_LOG     = 7,
  parameter int SLEN_LOG     = 6,
  parameter int LMUL_LOG_MAX = 3,
  parameter int IDX_W        = 7,
  parameter int ROFF_W       = 3,
  parameter int LMUL_CW      = 2
) (
  input  logic [1:0]         ew,
  input  logic [LMUL_CW-1:0] mul_code,
  input  logic [IDX_W-1:0]   idx,
  output logic [ROFF_W-1:0]  reg_off,
  output logic [IDX_W-1:0]   slot
);

  ew_code_e         ec;
  int               m_log;
  int               s_log;
  int               r_log;
  int               l_log;
  logic [IDX_W-1:0] s_mask;
  logic [IDX_W-1:0] l_mask;
  logic [IDX_W-1:0] strip_no;
  logic [IDX_W-1:0] strip_pos;
  logic [IDX_W-1:0] in_lane;

  always_comb begin
    ec    = ew_code_e'(ew);
    m_log = clamp_mul_log(int'(mul_code), LMUL_LOG_MAX);
    s_log = span_elems_log(SLEN_LOG, ec);
    r_log = span_elems_log(VLEN_LOG, ec);
    l_log = m_log + s_log;
    // power-of-two divide and modulo as shift and mask
    s_mask    = (IDX_W'(1) << s_log) - IDX_W'(1);
    l_mask    = (IDX_W'(1) << l_log) - IDX_W'(1);
    strip_no  = idx >> l_log;
    strip_pos = idx & s_mask;
    in_lane   = idx & l_mask;
    reg_off   = ROFF_W'(in_lane >> s_log);
    slot      = (IDX_W'(reg_off) << r_log) + (strip_no << s_log) + strip_pos;
  end

endmodule

// File: rtl/vsm_seq.sv
`timescale 1ns/1ps
module vsm_seq
  import vsm_pkg::*;
#(
  parameter int VLEN_LOG     = 7,
  parameter int LMUL_LOG_MAX = 3,
  parameter int IDX_W        = 7,
  parameter int LMUL_CW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         ew,
  input  logic [LMUL_CW-1:0] mul_code,
  output logic               busy,
  output logic               accept,
  output logic               last,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [1:0]         run_ew,
  output logic [LMUL_CW-1:0] run_mul
);

  int               vl_log;
  logic [IDX_W:0]   vl_cnt;
  logic [IDX_W-1:0] last_idx;

  always_comb begin
    vl_log   = group_elems_log(VLEN_LOG,
                               clamp_mul_log(int'(run_mul), LMUL_LOG_MAX),
                               ew_code_e'(run_ew));
    vl_cnt   = (IDX_W+1)'(1) << vl_log;
    last_idx = IDX_W'(vl_cnt - (IDX_W+1)'(1));
  end

  assign accept = start && !busy;
  assign last   = busy && (cur_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_idx <= '0;
      run_ew  <= '0;
      run_mul <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cur_idx <= '0;
      run_ew  <= ew;
      run_mul <= mul_code;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cur_idx <= cur_idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/vsm_beat_reg.sv
`timescale 1ns/1ps
module vsm_beat_reg #(
  parameter int IDX_W  = 7,
  parameter int ROFF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic              in_last,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [ROFF_W-1:0] in_reg,
  input  logic [IDX_W-1:0]  in_slot,
  output logic              out_valid,
  output logic              out_done,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ROFF_W-1:0] out_reg,
  output logic [IDX_W-1:0]  out_slot
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      out_idx   <= '0;
      out_reg   <= '0;
      out_slot  <= '0;
    end else begin
      out_valid <= in_fire;
      out_done  <= in_fire && in_last;
      if (in_fire) begin
        out_idx  <= in_idx;
        out_reg  <= in_reg;
        out_slot <= in_slot;
      end
    end
  end

endmodule

// File: rtl/vec_slot_mapper.sv
`timescale 1ns/1ps
module vec_slot_mapper #(
  parameter  int VLEN         = 128,
  parameter  int SLEN         = 64,
  parameter  int LMUL_MAX     = 8,
  localparam int VLEN_LOG     = $clog2(VLEN),
  localparam int SLEN_LOG     = $clog2(SLEN),
  localparam int LMUL_LOG_MAX = $clog2(LMUL_MAX),
  localparam int IDX_W        = LMUL_LOG_MAX + VLEN_LOG - 3,
  localparam int ROFF_W       = (LMUL_LOG_MAX < 1) ? 1 : LMUL_LOG_MAX,
  localparam int LMUL_CW      = (LMUL_LOG_MAX < 1) ? 1 : $clog2(LMUL_LOG_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         q_ew,
  input  logic [LMUL_CW-1:0] q_mul,
  input  logic [IDX_W-1:0]   q_idx,
  output logic [ROFF_W-1:0]  q_reg,
  output logic [IDX_W-1:0]   q_slot,
  input  logic               st_start,
  input  logic [1:0]         st_ew,
  input  logic [LMUL_CW-1:0] st_mul,
  output logic               st_busy,
  output logic               st_valid,
  output logic [IDX_W-1:0]   st_idx,
  output logic [ROFF_W-1:0]  st_reg,
  output logic [IDX_W-1:0]   st_slot,
  output logic               st_done
);

  // named internal events, observed by the bound checker
  logic               seq_busy;
  logic               seq_accept;
  logic               seq_last;
  logic [IDX_W-1:0]   seq_idx;
  logic [1:0]         run_ew;
  logic [LMUL_CW-1:0] run_mul;

  // mapping port 0 serves queries, port 1 serves the stream
  logic [1:0]         c_ew   [2];
  logic [LMUL_CW-1:0] c_mul  [2];
  logic [IDX_W-1:0]   c_idx  [2];
  logic [ROFF_W-1:0]  c_reg  [2];
  logic [IDX_W-1:0]   c_slot [2];

  assign c_ew[0]  = q_ew;
  assign c_mul[0] = q_mul;
  assign c_idx[0] = q_idx;
  assign c_ew[1]  = run_ew;
  assign c_mul[1] = run_mul;
  assign c_idx[1] = seq_idx;

  for (genvar g = 0; g < 2; g++) begin : g_map
    vsm_slot_calc #(
      .VLEN_LOG    (VLEN_LOG),
      .SLEN_LOG    (SLEN_LOG),
      .LMUL_LOG_MAX(LMUL_LOG_MAX),
      .IDX_W       (IDX_W),
      .ROFF_W      (ROFF_W),
      .LMUL_CW     (LMUL_CW)
    ) u_calc (
      .ew      (c_ew[g]),
      .mul_code(c_mul[g]),
      .idx     (c_idx[g]),
      .reg_off (c_reg[g]),
      .slot    (c_slot[g])
    );
  end

  assign q_reg  = c_reg[0];
  assign q_slot = c_slot[0];

  vsm_seq #(
    .VLEN_LOG    (VLEN_LOG),
    .LMUL_LOG_MAX(LMUL_LOG_MAX),
    .IDX_W       (IDX_W),
    .LMUL_CW     (LMUL_CW)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (st_start),
    .ew      (st_ew),
    .mul_code(st_mul),
    .busy    (seq_busy),
    .accept  (seq_accept),
    .last    (seq_last),
    .cur_idx (seq_idx),
    .run_ew  (run_ew),
    .run_mul (run_mul)
  );

  vsm_beat_reg #(
    .IDX_W (IDX_W),
    .ROFF_W(ROFF_W)
  ) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (seq_busy),
    .in_last  (seq_last),
    .in_idx   (seq_idx),
    .in_reg   (c_reg[1]),
    .in_slot  (c_slot[1]),
    .out_valid(st_valid),
    .out_done (st_done),
    .out_idx  (st_idx),
    .out_reg  (st_reg),
    .out_slot (st_slot)
  );

  assign st_busy = seq_busy;

endmodule

// File: rtl/vsm_chk.sv
`timescale 1ns/1ps
module vsm_chk
  import vsm_pkg::*;
#(
  parameter int VLEN_LOG     = 7,
  parameter int LMUL_LOG_MAX = 3,
  parameter int IDX_W        = 7,
  parameter int ROFF_W       = 3,
  parameter int LMUL_CW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         q_ew,
  input logic [LMUL_CW-1:0] q_mul,
  input logic [IDX_W-1:0]   q_idx,
  input logic [ROFF_W-1:0]  q_reg,
  input logic [IDX_W-1:0]   q_slot,
  input logic               seq_busy,
  input logic               seq_accept,
  input logic               seq_last,
  input logic [IDX_W-1:0]   seq_idx,
  input logic [1:0]         run_ew,
  input logic [LMUL_CW-1:0] run_mul,
  input logic               st_valid,
  input logic [IDX_W-1:0]   st_idx,
  input logic               st_done
);

  int q_mul_log;
  int q_vl;
  assign q_mul_log = clamp_mul_log(int'(q_mul), LMUL_LOG_MAX);
  assign q_vl      = 1 << group_elems_log(VLEN_LOG, q_mul_log, ew_code_e'(q_ew));

  assert_unit_mul_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mul == '0) |-> (q_slot == q_idx) && (q_reg == '0));

  assert_query_in_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_idx) < q_vl) |-> (int'(q_slot) < q_vl) && (int'(q_reg) < (1 << q_mul_log)));

  assert_accept_enters_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept |=> seq_busy && (seq_idx == '0));

  assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_done) |=> st_valid && (st_idx == $past(st_idx) + IDX_W'(1)));

  assert_setting_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !seq_last) |=> seq_busy && $stable(run_ew) && $stable(run_mul));

  assert_done_with_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> st_valid && !seq_busy);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> !st_done);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!seq_busy && !st_valid && !st_done);
    end
  end

endmodule

bind vec_slot_mapper vsm_chk #(
  .VLEN_LOG    (VLEN_LOG),
  .LMUL_LOG_MAX(LMUL_LOG_MAX),
  .IDX_W       (IDX_W),
  .ROFF_W      (ROFF_W),
  .LMUL_CW     (LMUL_CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .q_ew      (q_ew),
  .q_mul     (q_mul),
  .q_idx     (q_idx),
  .q_reg     (q_reg),
  .q_slot    (q_slot),
  .seq_busy  (seq_busy),
  .seq_accept(seq_accept),
  .seq_last  (seq_last),
  .seq_idx   (seq_idx),
  .run_ew    (run_ew),
  .run_mul   (run_mul),
  .st_valid  (st_valid),
  .st_idx    (st_idx),
  .st_done   (st_done)
);

// File: tb/vec_slot_mapper_test.sv
`timescale 1ns/1ps
module vec_slot_mapper_test;

  localparam int VLEN = 128;
  localparam int SLEN = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] q_ew = '0, q_mul = '0, st_ew = '0, st_mul = '0;
  logic [6:0] q_idx = '0;
  logic       st_start = 1'b0;
  logic [2:0] q_reg, st_reg;
  logic [6:0] q_slot, st_idx, st_slot;
  logic       st_busy, st_valid, st_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_slot_mapper #(.VLEN(VLEN), .SLEN(SLEN), .LMUL_MAX(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .q_ew(q_ew), .q_mul(q_mul), .q_idx(q_idx), .q_reg(q_reg), .q_slot(q_slot),
    .st_start(st_start), .st_ew(st_ew), .st_mul(st_mul), .st_busy(st_busy),
    .st_valid(st_valid), .st_idx(st_idx), .st_reg(st_reg), .st_slot(st_slot),
    .st_done(st_done)
  );

  // {ew code, mul code, index, expected reg offset, expected slot}
  localparam int NV = 9;
  localparam logic [20:0] TBL [NV] = '{
    {2'd0, 2'd1, 7'd9,   3'd1, 7'd17},  // R1 EW8 LMUL2, second register
    {2'd0, 2'd1, 7'd20,  3'd0, 7'd12},  // R1 EW8 LMUL2, second strip
    {2'd0, 2'd1, 7'd31,  3'd1, 7'd31},  // R1 last element of group
    {2'd0, 2'd3, 7'd100, 3'd4, 7'd76},  // R1 EW8 LMUL8
    {2'd2, 2'd2, 7'd13,  3'd2, 7'd11},  // R1 EW32 LMUL4
    {2'd3, 2'd3, 7'd11,  3'd3, 7'd7},   // R1 EW64 LMUL8, one-element strips
    {2'd3, 2'd3, 7'd15,  3'd7, 7'd15},  // R1 EW64 top register
    {2'd1, 2'd0, 7'd5,   3'd0, 7'd5},   // R3 unit multiplier is identity
    {2'd1, 2'd1, 7'd5,   3'd1, 7'd9}    // R1 EW16 LMUL2
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent restatement using true division
  function automatic void ref_map(input int e, input int m, input int idx,
                                  output int roff, output int slot);
    int ew, per_strip, per_reg, lane;
    ew        = 8 << e;
    per_strip = SLEN / ew;
    per_reg   = VLEN / ew;
    lane      = (1 << m) * per_strip;
    roff      = (idx % lane) / per_strip;
    slot      = roff * per_reg + (idx / lane) * per_strip + (idx % per_strip);
  endfunction

  function automatic int group_len(input int e, input int m);
    return ((1 << m) * VLEN) / (8 << e);
  endfunction

  task automatic run_stream(input int e, input int m, input bit disturb);
    int vl, ro, sl;
    vl = group_len(e, m);
    @(negedge clk);
    st_ew = 2'(e); st_mul = 2'(m); st_start = 1'b1;
    @(negedge clk);
    st_start = 1'b0;
    check("R5 busy after accepted start", int'(st_busy), 1);
    check("R5 no beat in accept cycle", int'(st_valid), 0);
    for (int k = 0; k < vl; k++) begin
      @(negedge clk);
      ref_map(e, m, k, ro, sl);
      check("R5 beat valid", int'(st_valid), 1);
      check("R5 beat index", int'(st_idx), k);
      check("R6 beat register offset", int'(st_reg), ro);
      check("R6 beat slot", int'(st_slot), sl);
      check("R7 done only on last beat", int'(st_done), (k == vl - 1) ? 1 : 0);
      if (disturb && k == 1) begin
        // R8: start and new setting while busy
        st_start = 1'b1;
        st_ew    = 2'((e + 1) % 4);
        st_mul   = 2'((m + 3) % 4);
      end else begin
        st_start = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 done cleared after run", int'(st_done), 0);
    check("R7 idle after run", int'(st_busy), 0);
    check("R7 no beat after run", int'(st_valid), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog: actual hung expected run complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ro, sl, vl, distinct;
    bit seen [128];

    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 busy in reset", int'(st_busy), 0);
    check("R9 valid in reset", int'(st_valid), 0);
    check("R9 done in reset", int'(st_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 busy after reset", int'(st_busy), 0);
    check("R9 valid after reset", int'(st_valid), 0);

    // R1/R3 hand-worked vectors
    for (int i = 0; i < NV; i++) begin
      q_ew  = TBL[i][20:19];
      q_mul = TBL[i][18:17];
      q_idx = TBL[i][16:10];
      #1;
      check("R1 table register offset", int'(q_reg), int'(TBL[i][9:7]));
      check("R1 table slot", int'(q_slot), int'(TBL[i][6:0]));
    end

    // R2/R4 full sweep of every code pair
    for (int e = 0; e < 4; e++) begin
      for (int m = 0; m < 4; m++) begin
        vl = group_len(e, m);
        for (int s = 0; s < 128; s++) seen[s] = 1'b0;
        distinct = 0;
        for (int ix = 0; ix < vl; ix++) begin
          q_ew = 2'(e); q_mul = 2'(m); q_idx = 7'(ix);
          #1;
          ref_map(e, m, ix, ro, sl);
          check("R2 sweep register offset", int'(q_reg), ro);
          check("R2 sweep slot", int'(q_slot), sl);
          if (m == 0) check("R3 identity", int'(q_slot), ix);
          if (int'(q_slot) < vl && !seen[q_slot]) begin
            seen[q_slot] = 1'b1;
            distinct++;
          end
        end
        check("R4 slots distinct within group", distinct, vl);
      end
    end

    // streaming runs
    run_stream(2, 1, 1'b0);   // EW32 LMUL2, 8 beats
    run_stream(2, 1, 1'b1);   // R8 disturbed mid-run
    run_stream(0, 3, 1'b0);   // EW8 LMUL8, 128 beats
    run_stream(3, 0, 1'b0);   // EW64 LMUL1, 2 beats

    // R9 reset cuts a run short
    @(negedge clk);
    st_ew = 2'd0; st_mul = 2'd2; st_start = 1'b1;
    @(negedge clk);
    st_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 reset clears busy", int'(st_busy), 0);
    check("R9 reset clears valid", int'(st_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 stays idle after reset", int'(st_valid), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule